// File: doc/BRIEF.md
# Multi-Source Readout Ready/Start Coordinator

This back-end block holds off event readout until every participating front-end unit has said it is ready. Each unit announces readiness on its own serial line with a short frame that carries the number of data words it holds. The coordinator stores each announced length and keeps one ready flag per unit. When all units selected by an enable mask have reported, it raises one start pulse that reaches every unit in the same cycle, so their transmissions begin together.

During readout each unit sends its data over four parallel lanes. A separate deserialiser, outside this block, turns that data into one word strobe per received word. The coordinator counts these strobes against each unit's announced length. It ends the event when every enabled unit has delivered exactly its length, or when a timeout expires. At the end of the event it pulses an event-done output, publishes per-unit length and protocol error flags, and clears every ready flag so the next event needs fresh reports.

Top module: `rdo_coordinator`

## Requirements
- R1: A ready frame on a unit's serial line has this format. The line idles low, a start bit is 1, then a 2-bit code follows least significant bit first, then a 16-bit length follows least significant bit first. Only the code value 2'b10 registers a ready; a frame with any other code has no effect.
- R2: A unit whose `src_en` bit is 0 is left out of the all-ready decision. Its frames and word strobes have no effect on `start`, `len_err` or `proto_err`.
- R3: `start` is a single-cycle pulse. It is raised once per event, only after every enabled unit has reported ready, and never before.
- R4: `busy` is high from the `start` pulse until the event ends, and it is low again in the cycle `evt_done` is high.
- R5: Each enabled unit's word strobes are counted during readout. When every enabled unit's count equals its announced length, `evt_done` pulses once. A unit that announces length 0 counts as finished at once.
- R6: A word strobe that arrives during readout after a unit has already reached its length sets that unit's `len_err` bit.
- R7: If readout has not finished `TMO_CYC` cycles after start, the event ends anyway. Every enabled unit whose count is short of its length then gets its `len_err` bit set.
- R8: A second ready frame from an enabled unit that is already ready in the current event sets that unit's `proto_err` bit.
- R9: `len_err` and `proto_err` update together with `evt_done` and hold until the next `evt_done`. All ready flags clear at `evt_done`, so no new `start` is issued without fresh ready frames.
- R10: After reset, `start`, `busy` and `evt_done` are low, and all error bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | NSRC | Per-unit participation mask |
| rdy_ser | input | NSRC | Per-unit serial ready-frame lines |
| word_stb | input | NSRC | Per-unit received-word strobes |
| start | output | 1 | Common readout start pulse |
| busy | output | 1 | Readout in progress |
| evt_done | output | 1 | Event completion pulse |
| len_err | output | NSRC | Per-unit length mismatch or timeout flag, last event |
| proto_err | output | NSRC | Per-unit duplicate-ready flag, last event |

## Verification
Faults in the internal state show up at the ports in predictable ways:
- A ready flag that sets wrongly, or never clears, shows up as a `start` pulse a few cycles after the wrong frame, or after an event with no new reports.
- A ready flag that is lost shows up as no `start` once the last good frame has finished.
- A wrong stored length or a broken word counter shows up when the event ends. Either `evt_done` comes early, or it arrives only at the timeout, with `len_err` bits that differ from the words the bench sent.
- A stuck duplicate-ready flag shows up in `proto_err` at the end of the event, and it remains visible until the next event ends.

// File: rtl/rdo_coord_pkg.sv
package rdo_coord_pkg;
  typedef enum logic {PH_COLLECT, PH_RUN} phase_t;
  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] READY_CODE = 2'b10;
endpackage

// File: rtl/rdo_frame_rx.sv
module rdo_frame_rx
  import rdo_coord_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  output logic             rdy_evt_o,
  output logic [LEN_W-1:0] len_o
);
  localparam int PAY_W = CODE_W + LEN_W;
  localparam int CNT_W = $clog2(PAY_W + 1);

  logic [CNT_W-1:0] bit_q, bit_d;
  logic [PAY_W-1:0] sr_q, sr_d;
  logic             evt_q, evt_d;
  logic [LEN_W-1:0] len_q, len_d;

  always_comb begin
    bit_d = bit_q;
    sr_d  = sr_q;
    evt_d = 1'b0;
    len_d = len_q;
    if (bit_q == '0) begin
      if (line_i) bit_d = CNT_W'(1);
    end else begin
      sr_d = {line_i, sr_q[PAY_W-1:1]};
      if (bit_q == CNT_W'(PAY_W)) begin
        bit_d = '0;
        evt_d = (sr_d[CODE_W-1:0] == READY_CODE);
        len_d = sr_d[PAY_W-1:CODE_W];
      end else begin
        bit_d = bit_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      sr_q  <= '0;
      evt_q <= 1'b0;
      len_q <= '0;
    end else begin
      bit_q <= bit_d;
      sr_q  <= sr_d;
      evt_q <= evt_d;
      len_q <= len_d;
    end
  end

  assign rdy_evt_o = evt_q;
  assign len_o     = len_q;
endmodule

// File: rtl/rdo_src_track.sv
module rdo_src_track #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rdy_evt_i,
  input  logic [LEN_W-1:0] rdy_len_i,
  input  logic             word_stb_i,
  input  logic             run_i,
  input  logic             evt_end_i,
  input  logic             tmo_i,
  output logic             rdy_o,
  output logic             fin_o,
  output logic             len_err_o,
  output logic             proto_err_o
);
  logic             rdy_q, rdy_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             lw_q, lw_d, pw_q, pw_d;
  logic             le_q, le_d, pe_q, pe_d;
  logic             fin;

  assign fin = !en_i || (rdy_q && (cnt_q == len_q));

  always_comb begin
    rdy_d = rdy_q;
    len_d = len_q;
    cnt_d = cnt_q;
    lw_d  = lw_q;
    pw_d  = pw_q;
    le_d  = le_q;
    pe_d  = pe_q;
    if (evt_end_i) begin
      le_d  = lw_q || (tmo_i && !fin);
      pe_d  = pw_q;
      rdy_d = 1'b0;
      cnt_d = '0;
      lw_d  = 1'b0;
      pw_d  = 1'b0;
    end else begin
      if (rdy_evt_i && en_i) begin
        if (rdy_q) begin
          pw_d = 1'b1;
        end else begin
          rdy_d = 1'b1;
          len_d = rdy_len_i;
        end
      end
      if (run_i && en_i && word_stb_i) begin
        if (fin) lw_d = 1'b1;
        else     cnt_d = cnt_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      len_q <= '0;
      cnt_q <= '0;
      lw_q  <= 1'b0;
      pw_q  <= 1'b0;
      le_q  <= 1'b0;
      pe_q  <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      len_q <= len_d;
      cnt_q <= cnt_d;
      lw_q  <= lw_d;
      pw_q  <= pw_d;
      le_q  <= le_d;
      pe_q  <= pe_d;
    end
  end

  assign rdy_o       = rdy_q;
  assign fin_o       = fin;
  assign len_err_o   = le_q;
  assign proto_err_o = pe_q;
endmodule

// File: rtl/rdo_coordinator.sv
module rdo_coordinator
  import rdo_coord_pkg::*;
#(
  parameter int NSRC    = 8,
  parameter int LEN_W   = 16,
  parameter int TMO_CYC = 4096
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] rdy_ser,
  input  logic [NSRC-1:0] word_stb,
  output logic            start,
  output logic            busy,
  output logic            evt_done,
  output logic [NSRC-1:0] len_err,
  output logic [NSRC-1:0] proto_err
);
  localparam int TMR_W = $clog2(TMO_CYC + 1);

  phase_t            ph_q, ph_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic              start_q, start_d;
  logic              done_q, done_d;
  logic [NSRC-1:0]   rdy_vec, fin_vec;
  logic              all_rdy, run, tmo, evt_end;

  assign run     = (ph_q == PH_RUN);
  assign all_rdy = (&(rdy_vec | ~src_en)) && (|src_en);
  assign tmo     = run && (tmr_q == TMR_W'(TMO_CYC - 1));
  assign evt_end = run && ((&fin_vec) || tmo);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic             evt;
    logic [LEN_W-1:0] len;

    rdo_frame_rx #(.LEN_W(LEN_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_i    (rdy_ser[g]),
      .rdy_evt_o (evt),
      .len_o     (len)
    );

    rdo_src_track #(.LEN_W(LEN_W)) u_trk (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (src_en[g]),
      .rdy_evt_i   (evt),
      .rdy_len_i   (len),
      .word_stb_i  (word_stb[g]),
      .run_i       (run),
      .evt_end_i   (evt_end),
      .tmo_i       (tmo),
      .rdy_o       (rdy_vec[g]),
      .fin_o       (fin_vec[g]),
      .len_err_o   (len_err[g]),
      .proto_err_o (proto_err[g])
    );
  end

  always_comb begin
    ph_d    = ph_q;
    tmr_d   = tmr_q;
    start_d = 1'b0;
    done_d  = 1'b0;
    if (run) begin
      tmr_d = tmr_q + TMR_W'(1);
      if (evt_end) begin
        ph_d   = PH_COLLECT;
        done_d = 1'b1;
      end
    end else if (all_rdy) begin
      ph_d    = PH_RUN;
      tmr_d   = '0;
      start_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_COLLECT;
      tmr_q   <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      tmr_q   <= tmr_d;
      start_q <= start_d;
      done_q  <= done_d;
    end
  end

  assign start    = start_q;
  assign busy     = run;
  assign evt_done = done_q;
endmodule

// File: rtl/rdo_coordinator_chk.sv
module rdo_coordinator_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            evt_done,
  input logic [NSRC-1:0] rdy_vec,
  input logic [NSRC-1:0] src_en
);
  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  // R3
  start_all_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ((rdy_vec | ~src_en) == {NSRC{1'b1}}));
  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> !busy);
  // R5
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> $past(busy));
  // R9
  rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> (rdy_vec == '0));
endmodule

bind rdo_coordinator rdo_coordinator_chk #(.NSRC(NSRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .evt_done (evt_done),
  .rdy_vec  (rdy_vec),
  .src_en   (src_en)
);

// File: tb/rdo_coordinator_test.sv
module rdo_coordinator_test;
  localparam int N   = 8;
  localparam int TMO = 600;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] src_en, rdy_ser, word_stb;
  logic         start, busy, evt_done;
  logic [N-1:0] len_err, proto_err;

  int n_chk = 0, n_err = 0;
  int start_cnt = 0, done_cnt = 0;
  int ev_len [N];
  int ev_words [N];
  bit finished = 0;

  rdo_coordinator #(.NSRC(N), .LEN_W(16), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .rdy_ser(rdy_ser),
    .word_stb(word_stb), .start(start), .busy(busy), .evt_done(evt_done),
    .len_err(len_err), .proto_err(proto_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) if (rst_n) begin
    if (start)    start_cnt++;
    if (evt_done) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_frame(input int s, input logic [1:0] code, input logic [15:0] len);
    @(negedge clk) rdy_ser[s] = 1'b1;
    for (int i = 0; i < 2; i++)  begin @(negedge clk) rdy_ser[s] = code[i]; end
    for (int i = 0; i < 16; i++) begin @(negedge clk) rdy_ser[s] = len[i]; end
    @(negedge clk) rdy_ser[s] = 1'b0;
  endtask

  task automatic send_words(input int s, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) word_stb[s] = 1'b1;
      @(negedge clk) word_stb[s] = 1'b0;
    end
  endtask

  function automatic logic [N-1:0] exp_lerr(input logic [N-1:0] en);
    logic [N-1:0] r = '0;
    for (int s = 0; s < N; s++) r[s] = en[s] && (ev_words[s] != ev_len[s]);
    return r;
  endfunction

  task automatic run_event(input logic [N-1:0] en, input bit dup_pre,
                           input bit dup_run, input int bad);
    int s0, d0, first, last;
    logic [N-1:0] eperr, elerr;
    eperr = '0;
    first = -1; last = -1;
    for (int s = 0; s < N; s++) if (en[s]) begin
      if (first < 0) first = s;
      last = s;
    end
    src_en = en;
    @(negedge clk);
    s0 = start_cnt; d0 = done_cnt;
    if (dup_pre && first != last) begin
      send_frame(first, 2'b10, 16'(ev_len[first]));
      eperr[first] = 1'b1;
    end
    if (bad >= 0) begin
      send_frame(bad, 2'b01, 16'(ev_len[bad]));
      repeat (4) @(negedge clk);
      chk(start_cnt == s0, "R1", "start after bad-code frame", start_cnt, s0);
    end
    for (int s = 0; s < N; s++) if (!en[s]) send_frame(s, 2'b10, 16'd5);
    for (int s = 0; s < N; s++) if (en[s]) begin
      send_frame(s, 2'b10, 16'(ev_len[s]));
      repeat (5) @(negedge clk);
      if (s != last)
        chk(start_cnt == s0, "R3", "start before all ready", start_cnt, s0);
    end
    chk(start_cnt == s0 + 1, "R3", "single start after all ready", start_cnt, s0 + 1);
    if (dup_run) begin
      send_frame(first, 2'b10, 16'(ev_len[first]));
      eperr[first] = 1'b1;
    end
    for (int s = 0; s < N; s++) begin
      if (en[s]) send_words(s, ev_words[s]);
      else       send_words(s, 3);
    end
    for (int i = 0; i < TMO + 200 && done_cnt == d0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    elerr = exp_lerr(en);
    chk(done_cnt == d0 + 1, "R5", "event done pulses", done_cnt, d0 + 1);
    chk(busy == 1'b0, "R4", "busy after done", busy, 0);
    chk(len_err == elerr, "R6", "len_err (R7 timeout)", len_err, elerr);
    chk(proto_err == eperr, "R8", "proto_err", proto_err, eperr);
    repeat (25) @(negedge clk);
    chk(start_cnt == s0 + 1, "R9", "no start without fresh ready", start_cnt, s0 + 1);
    chk(len_err == elerr, "R9", "len_err held", len_err, elerr);
  endtask

  task automatic set_all(input int len, input int words);
    for (int s = 0; s < N; s++) begin ev_len[s] = len; ev_words[s] = words; end
  endtask

  initial begin
    rst_n = 1'b0; src_en = '0; rdy_ser = '0; word_stb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(start == 0 && busy == 0 && evt_done == 0, "R10", "control outputs after reset",
        {start, busy, evt_done}, 0);
    chk(len_err == 0 && proto_err == 0, "R10", "error bits after reset",
        {len_err, proto_err}, 0);

    set_all(3, 3);                          run_event(8'hFF, 0, 0, -1); // R5 all units
    set_all(0, 0);                          run_event(8'h09, 0, 0, -1); // R5 zero length
    set_all(4, 4); ev_words[0] = 5;         run_event(8'h03, 0, 0, -1); // R6 overflow
    set_all(4, 4); ev_words[2] = 2;         run_event(8'h0F, 0, 0, -1); // R7 timeout
    set_all(2, 2);                          run_event(8'h11, 1, 0, -1); // R8 before start
    set_all(4, 4);                          run_event(8'h81, 0, 1, -1); // R8 during readout
    set_all(3, 3);                          run_event(8'h06, 0, 0, 1);  // R1 bad code
    set_all(2, 2);                          run_event(8'h24, 0, 0, -1); // R2, R9 clean again

    void'($urandom(32'd4242));
    for (int k = 0; k < 6; k++) begin
      logic [N-1:0] en;
      en = N'($urandom) | N'(1 << ($urandom % N));
      for (int s = 0; s < N; s++) begin
        ev_len[s]   = $urandom % 13;
        ev_words[s] = ev_len[s];
        if (ev_len[s] > 0 && ($urandom % 5) == 0) ev_words[s] = ev_len[s] - 1;
      end
      run_event(en, 0, 0, -1);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule